// File: doc/BRIEF.md
# Frame-Boundary Shadow Register Bank for Overlay Windows

This block holds the per-window configuration of a display overlay engine in two copies. Software writes through a simple register port into a pending copy. The scan-out logic only ever sees the active copy. The active copy of a window is reloaded from its pending copy on the frame synchronisation strobe (vsync), at the same moment the frame fetch begins. A window therefore never scans out a half-written set of values.

Each window has a protect input. While it is high, vsync leaves that window's active copy alone. Software raises every protect bit before a batch of updates and lowers them all afterwards, so the whole batch lands at the first vsync after the release. Each window's active buffer start address can be read back beside the pending one. When the two are equal, software knows the new address is in use. Clearing a window's enable also waits for vsync, so a buffer can be freed safely once the change shows in the readback.

The block carries no data stream. Its register port, vsync strobe, protect bits and active-value outputs are plain control and status pins with no valid/ready handshake. A write is always accepted in the cycle it is presented, and no back-pressure exists.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset, every pending and active field of every window is zero, and every register reads back as zero.
- R2: A write with `wen` high updates the pending field selected by `waddr`. `waddr[5:3]` selects the window and `waddr[2:0]` selects the register: 0 is control, 1 is buffer start, 2 is buffer end, 3 is span, 4 is top-left and 5 is bottom-right. The write is readable one cycle after `rd_addr` selects it. The active outputs do not change without vsync.
- R3: On a clock edge where `vsync` is high and the window's `prot` bit is low, every active field of that window takes the pending value held before that edge. The new value is visible on the `act_*` outputs from that edge on.
- R4: While a window's `prot` bit is high, vsync leaves its active copy unchanged. The pending values move at the first vsync seen with the bit low.
- R5: Protect bits are not shadowed. A `prot` bit that rises in the same cycle as `vsync` already blocks that transfer.
- R6: A write presented in the same cycle as `vsync` goes to pending only. The active copy takes the pending value from before the write, and the written value moves at the following vsync.
- R7: Register offset 6 of a window is read-only and returns that window's active buffer start. Offset 1 returns the pending buffer start. The two match once a transfer has taken place.
- R8: Writing 0 to control bit 0 (enable) leaves `act_en` high until the next unprotected vsync, and the bit clears there.
- R9: Windows are independent. A write, or a protect bit, of one window has no effect on the pending or active values of any other window.
- R10: Writes to offsets 6 or 7, or to a window index of NWIN or above, change nothing. Reads of offset 7, or of a window index of NWIN or above, return zero.
- R11: In the span register, bits [31:16] hold the line offset and bits [15:0] hold the page width. In both position registers, bits [31:16] hold y and bits [15:0] hold x. In the control register, bit 0 is the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wen | input | 1 | Register write strobe |
| waddr | input | 6 | Write address: {window, register} |
| wdata | input | 32 | Write data |
| rd_addr | input | 6 | Read address: {window, register} |
| rd_data | output | 32 | Read data, registered one cycle after rd_addr |
| vsync | input | 1 | Frame boundary strobe, one cycle wide |
| prot | input | 5 | Per-window transfer protect |
| act_en | output | 5 | Active enable per window |
| act_start | output | 5x32 | Active buffer start per window |
| act_end | output | 5x32 | Active buffer end per window |
| act_loff | output | 5x16 | Active line offset per window |
| act_pwid | output | 5x16 | Active page width per window |
| act_tlx | output | 5x16 | Active top-left x per window |
| act_tly | output | 5x16 | Active top-left y per window |
| act_brx | output | 5x16 | Active bottom-right x per window |
| act_bry | output | 5x16 | Active bottom-right y per window |

## Verification
A write reaches pending on the edge that samples `wen`. It can be read at the falling edge one cycle after `rd_addr` is set, because read data passes through one register. Active values change only on the edge that samples `vsync`, so the bench raises inputs at a falling edge and compares the `act_*` outputs at the next falling edge. It also checks them at the falling edge before the vsync, to confirm that nothing moved early. Cases that depend on same-cycle ordering drive both inputs on the same falling edge. These cases are a write during vsync and a protect rising during vsync. The bench then checks the outputs one and two vsyncs later.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 32;
  parameter int COORD_W   = 16;
  parameter int REG_SEL_W = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_CTRL      = 3'd0,
    SEL_START     = 3'd1,
    SEL_END       = 3'd2,
    SEL_SPAN      = 3'd3,
    SEL_TL        = 3'd4,
    SEL_BR        = 3'd5,
    SEL_ACT_START = 3'd6,
    SEL_NONE      = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic               en;
    logic [ADDR_W-1:0]  start;
    logic [ADDR_W-1:0]  fin;
    logic [COORD_W-1:0] loff;
    logic [COORD_W-1:0] pwid;
    logic [COORD_W-1:0] tlx;
    logic [COORD_W-1:0] tly;
    logic [COORD_W-1:0] brx;
    logic [COORD_W-1:0] bry;
  } win_regs_t;
endpackage

// File: rtl/vsb_wr_decode.sv
module vsb_wr_decode
  import vsb_pkg::*;
#(
  parameter int NWIN  = 5,
  parameter int WIN_W = 3
) (
  input  logic                       wen,
  input  logic [WIN_W+REG_SEL_W-1:0] waddr,
  output logic [NWIN-1:0]            hit,
  output reg_sel_e                   sel
);
  logic [WIN_W-1:0] win_idx;
  logic             writable;

  assign win_idx  = waddr[WIN_W+REG_SEL_W-1:REG_SEL_W];
  assign sel      = reg_sel_e'(waddr[REG_SEL_W-1:0]);
  assign writable = (sel != SEL_ACT_START) && (sel != SEL_NONE);

  for (genvar i = 0; i < NWIN; i++) begin : g_hit
    assign hit[i] = wen && writable && (win_idx == WIN_W'(i));
  end
endmodule

// File: rtl/vsb_win_regs.sv
module vsb_win_regs
  import vsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vsync,
  input  logic              prot,
  output win_regs_t         pend,
  output win_regs_t         act
);
  localparam int HI = 2*COORD_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (wr_hit) begin
      unique case (wr_sel)
        SEL_CTRL:  pend.en    <= wr_data[0];
        SEL_START: pend.start <= wr_data[ADDR_W-1:0];
        SEL_END:   pend.fin   <= wr_data[ADDR_W-1:0];
        SEL_SPAN: begin
          pend.loff <= wr_data[HI:COORD_W];
          pend.pwid <= wr_data[COORD_W-1:0];
        end
        SEL_TL: begin
          pend.tly <= wr_data[HI:COORD_W];
          pend.tlx <= wr_data[COORD_W-1:0];
        end
        SEL_BR: begin
          pend.bry <= wr_data[HI:COORD_W];
          pend.brx <= wr_data[COORD_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
    end else if (vsync && !prot) begin
      act <= pend;
    end
  end
endmodule

// File: rtl/vsb_rd_mux.sv
module vsb_rd_mux
  import vsb_pkg::*;
#(
  parameter int NWIN  = 5,
  parameter int WIN_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [WIN_W+REG_SEL_W-1:0]       rd_addr,
  input  win_regs_t [NWIN-1:0]             pend,
  input  logic [NWIN-1:0][ADDR_W-1:0]      act_start,
  output logic [DATA_W-1:0]                rd_data
);
  logic [WIN_W-1:0]  win_idx;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_next;

  assign win_idx = rd_addr[WIN_W+REG_SEL_W-1:REG_SEL_W];
  assign sel     = reg_sel_e'(rd_addr[REG_SEL_W-1:0]);

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (win_idx == WIN_W'(i)) begin
        unique case (sel)
          SEL_CTRL:      rd_next = DATA_W'(pend[i].en);
          SEL_START:     rd_next = DATA_W'(pend[i].start);
          SEL_END:       rd_next = DATA_W'(pend[i].fin);
          SEL_SPAN:      rd_next = {pend[i].loff, pend[i].pwid};
          SEL_TL:        rd_next = {pend[i].tly, pend[i].tlx};
          SEL_BR:        rd_next = {pend[i].bry, pend[i].brx};
          SEL_ACT_START: rd_next = DATA_W'(act_start[i]);
          default:       rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end
endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank
  import vsb_pkg::*;
#(
  parameter int NWIN  = 5,
  parameter int WIN_W = $clog2(NWIN),
  parameter int RA_W  = WIN_W + REG_SEL_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wen,
  input  logic [RA_W-1:0]               waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [RA_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  input  logic                          vsync,
  input  logic [NWIN-1:0]               prot,
  output logic [NWIN-1:0]               act_en,
  output logic [NWIN-1:0][ADDR_W-1:0]   act_start,
  output logic [NWIN-1:0][ADDR_W-1:0]   act_end,
  output logic [NWIN-1:0][COORD_W-1:0]  act_loff,
  output logic [NWIN-1:0][COORD_W-1:0]  act_pwid,
  output logic [NWIN-1:0][COORD_W-1:0]  act_tlx,
  output logic [NWIN-1:0][COORD_W-1:0]  act_tly,
  output logic [NWIN-1:0][COORD_W-1:0]  act_brx,
  output logic [NWIN-1:0][COORD_W-1:0]  act_bry
);
  logic [NWIN-1:0]             wr_hit;
  reg_sel_e                    wr_sel;
  win_regs_t [NWIN-1:0]        pend;
  win_regs_t [NWIN-1:0]        act;
  logic [NWIN-1:0][ADDR_W-1:0] pend_start;

  vsb_wr_decode #(.NWIN(NWIN), .WIN_W(WIN_W)) u_dec (
    .wen   (wen),
    .waddr (waddr),
    .hit   (wr_hit),
    .sel   (wr_sel)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    vsb_win_regs u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit[i]),
      .wr_sel  (wr_sel),
      .wr_data (wdata),
      .vsync   (vsync),
      .prot    (prot[i]),
      .pend    (pend[i]),
      .act     (act[i])
    );
    assign act_en[i]     = act[i].en;
    assign act_start[i]  = act[i].start;
    assign act_end[i]    = act[i].fin;
    assign act_loff[i]   = act[i].loff;
    assign act_pwid[i]   = act[i].pwid;
    assign act_tlx[i]    = act[i].tlx;
    assign act_tly[i]    = act[i].tly;
    assign act_brx[i]    = act[i].brx;
    assign act_bry[i]    = act[i].bry;
    assign pend_start[i] = pend[i].start;
  end

  vsb_rd_mux #(.NWIN(NWIN), .WIN_W(WIN_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (rd_addr),
    .pend      (pend),
    .act_start (act_start),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker
  import vsb_pkg::*;
#(
  parameter int NWIN = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        vsync,
  input logic [NWIN-1:0]             prot,
  input logic [NWIN-1:0]             act_en,
  input logic [NWIN-1:0][ADDR_W-1:0] act_start,
  input logic [NWIN-1:0][ADDR_W-1:0] pend_start
);
  AST_ACT_HOLD_NO_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_start)); // R2
  AST_EN_WAITS_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_en)); // R8

  for (genvar i = 0; i < NWIN; i++) begin : g_chk
    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && prot[i]) |=> $stable(act_start[i])); // R4
    AST_XFER_PREV_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !prot[i]) |=> (act_start[i] == $past(pend_start[i]))); // R3
  end
endmodule

bind vsync_shadow_bank vsb_checker #(.NWIN(NWIN)) u_vsb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsync      (vsync),
  .prot       (prot),
  .act_en     (act_en),
  .act_start  (act_start),
  .pend_start (pend_start)
);

// File: tb/vsync_shadow_bank_tb_top.sv
module vsync_shadow_bank_tb_top;
  localparam int NWIN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen = 1'b0;
  logic [5:0] waddr = '0;
  logic [31:0] wdata = '0;
  logic [5:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic vsync = 1'b0;
  logic [NWIN-1:0] prot = '0;
  logic [NWIN-1:0] act_en;
  logic [NWIN-1:0][31:0] act_start, act_end;
  logic [NWIN-1:0][15:0] act_loff, act_pwid, act_tlx, act_tly, act_brx, act_bry;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vsync_shadow_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wen(wen), .waddr(waddr), .wdata(wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync), .prot(prot),
    .act_en(act_en), .act_start(act_start), .act_end(act_end),
    .act_loff(act_loff), .act_pwid(act_pwid), .act_tlx(act_tlx),
    .act_tly(act_tly), .act_brx(act_brx), .act_bry(act_bry)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int w, input int r, input logic [31:0] d);
    @(negedge clk);
    wen = 1'b1; waddr = {3'(w), 3'(r)}; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic vs();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic wr_vs(input int w, input int r, input logic [31:0] d);
    @(negedge clk);
    wen = 1'b1; waddr = {3'(w), 3'(r)}; wdata = d; vsync = 1'b1;
    @(negedge clk);
    wen = 1'b0; vsync = 1'b0;
  endtask

  task automatic rd(input int w, input int r, output logic [31:0] d);
    @(negedge clk);
    rd_addr = {3'(w), 3'(r)};
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 1, d); chk("R1 pend start w0", d, 0);
    rd(4, 3, d); chk("R1 pend span w4", d, 0);
    rd(2, 6, d); chk("R1 act start readback w2", d, 0);
    chk("R1 act_start all", 32'(act_start == '0), 1);
    chk("R1 act_en all", 32'(act_en), 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(0, 1, 32'h0000_1000);
    rd(0, 1, d); chk("R2 pend start readable", d, 32'h1000);
    chk("R2 active unchanged before vsync", act_start[0], 0);
    rd(0, 6, d); chk("R7 active readback before vsync", d, 0);
    vs();
    chk("R3 active start after vsync", act_start[0], 32'h1000);
    rd(0, 6, d); chk("R7 active readback matches pend", d, 32'h1000);
  endtask

  task automatic t_fields();
    wr(1, 2, 32'h0000_9000);
    wr(1, 3, 32'h0020_0140);
    wr(1, 4, 32'h0010_0008);
    wr(1, 5, 32'h00F0_0148);
    chk("R3 end not yet moved", act_end[1], 0);
    vs();
    chk("R3 end moved", act_end[1], 32'h9000);
    chk("R11 line offset", 32'(act_loff[1]), 32'h20);
    chk("R11 page width", 32'(act_pwid[1]), 32'h140);
    chk("R11 top-left x", 32'(act_tlx[1]), 32'h8);
    chk("R11 top-left y", 32'(act_tly[1]), 32'h10);
    chk("R11 bottom-right x", 32'(act_brx[1]), 32'h148);
    chk("R11 bottom-right y", 32'(act_bry[1]), 32'hF0);
  endtask

  task automatic t_protect();
    logic [31:0] d;
    @(negedge clk); prot[1] = 1'b1;
    wr(1, 1, 32'h0000_2000);
    wr(0, 1, 32'h0000_3000);
    vs();
    chk("R4 protected window held", act_start[1], 0);
    chk("R9 unprotected window moved", act_start[0], 32'h3000);
    rd(1, 6, d); chk("R7 readback differs while protected", d, 0);
    @(negedge clk); prot[1] = 1'b0;
    chk("R4 no move on release alone", act_start[1], 0);
    vs();
    chk("R4 moved at first vsync after release", act_start[1], 32'h2000);
  endtask

  task automatic t_prot_same();
    wr(2, 1, 32'h0000_4000);
    @(negedge clk); prot[2] = 1'b1; vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    chk("R5 protect in vsync cycle blocks", act_start[2], 0);
    @(negedge clk); prot[2] = 1'b0;
    vs();
    chk("R5 moves after release", act_start[2], 32'h4000);
  endtask

  task automatic t_coincide();
    logic [31:0] d;
    wr(3, 1, 32'h0000_5000);
    wr_vs(3, 1, 32'h0000_6000);
    chk("R6 active took previous pending", act_start[3], 32'h5000);
    rd(3, 1, d); chk("R6 write in vsync cycle reached pending", d, 32'h6000);
    vs();
    chk("R6 moved at next vsync", act_start[3], 32'h6000);
  endtask

  task automatic t_enable();
    wr(4, 0, 32'h1);
    vs();
    chk("R8 enable set after vsync", 32'(act_en[4]), 1);
    wr(4, 0, 32'h0);
    chk("R8 enable still high before vsync", 32'(act_en[4]), 1);
    vs();
    chk("R8 enable cleared at vsync", 32'(act_en[4]), 0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(0, 6, 32'hDEAD_BEEF);
    rd(0, 6, d); chk("R10 write to readback ignored", d, 32'h3000);
    rd(0, 1, d); chk("R10 pending start untouched", d, 32'h3000);
    wr(0, 7, 32'hDEAD_BEEF);
    rd(0, 7, d); chk("R10 offset 7 reads zero", d, 0);
    wr(5, 1, 32'hCAFE_0000);
    rd(5, 1, d); chk("R10 nonexistent window reads zero", d, 0);
    wr(7, 1, 32'hCAFE_1111);
    rd(2, 1, d); chk("R9 other window untouched", d, 32'h4000);
    vs();
    chk("R10 w0 active unchanged", act_start[0], 32'h3000);
    chk("R10 w4 active unchanged", act_start[4], 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_fields();
    t_protect();
    t_prot_same();
    t_coincide();
    t_enable();
    t_ignore();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule